// File: doc/BRIEF.md
# Load Address Hazard Gate

This block decides, cycle by cycle, whether a pending load may start its memory access or must hold back. It keeps a small record of every store that has entered the reorder buffer but not yet committed. Each record sits in the slot with the same index as the store's reorder-buffer position. A record holds a valid flag, an address-known flag and the store's full 32-bit effective address.

Stores claim their slot in program order when they are dispatched. They fill in the address once address generation produces it, and they release the slot when they commit at the buffer head. A flush releases every slot younger than a given point, or releases all slots at once. A load presents its own reorder-buffer index and its address. The block grants the access only when no older live store could write the same location. An older store whose address is still unknown counts as a possible writer.

Age is measured as the distance of an index from the current head, modulo the buffer depth, so the comparison works across wrap-around. Memory is written only at commit from the head, in program order, so write-after-write and write-after-read ordering through memory needs no check here. The gate only enforces read-after-write ordering.

Top module: `ldHazardGate`

## Requirements
- R1: After reset no store slot is live, so any presented load is granted.
- R2: A live store whose address is not yet known, and that is older than the load, holds the load back (loadGrant low).
- R3: A live older store whose known address equals the load address over all 32 bits holds the load back.
- R4: A live older store whose known address differs from the load address does not hold the load back.
- R5: Age is the index minus headIdx, modulo DEPTH (default 8). Only slots with a strictly smaller distance than the load's distance are compared; younger stores never block, including across index wrap-around.
- R6: A commit releases the slot at commitIdx on the next clock edge, and commitIdx always equals headIdx.
- R7: A flush with flushValid releases every slot whose distance from the head is strictly greater than the distance of flushIdx, and keeps the slot at flushIdx. flushAll releases every slot, including one allocated in the same cycle.
- R8: loadGrant is low whenever loadValid is low.
- R9: An address update to a slot that is not live is ignored; the slot stays unknown if it is allocated later. An allocation clears the address-known flag of its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| headIdx | input | 3 | Current reorder-buffer head index |
| allocValid | input | 1 | A store is dispatched this cycle |
| allocIdx | input | 3 | Reorder-buffer index of the dispatched store |
| addrValid | input | 1 | A store address is delivered this cycle |
| addrIdx | input | 3 | Index of the store receiving the address |
| addrValue | input | 32 | Store effective address |
| commitValid | input | 1 | The store at the head commits this cycle |
| commitIdx | input | 3 | Index of the committing store |
| flushValid | input | 1 | Partial flush request |
| flushIdx | input | 3 | Youngest index kept by the partial flush |
| flushAll | input | 1 | Release every slot |
| loadValid | input | 1 | A load asks for memory access |
| loadIdx | input | 3 | Reorder-buffer index of the load |
| loadAddr | input | 32 | Load effective address |
| loadGrant | output | 1 | Load may access memory this cycle |

## Verification
The assertions watch, on every cycle, the rules that hold on their own. Commits only ever come from the head. A freshly allocated slot is live with an unknown address. An address written to a dead slot leaves it unknown. A full flush leaves no live slot. No grant is given without a request. Whether the grant is correct depends on which stores exist, how old they are and what addresses they hold, and only the bench's scenarios can show that. These scenarios cover unknown and matching older stores, younger stores, head wrap-around, partial and full flush, and commit.

// File: rtl/ldHazardPkg.sv
package ldHazardPkg;
  parameter int unsigned HZ_DEPTH = 8;
  parameter int unsigned HZ_ADDRW = 32;
  localparam int unsigned HZ_IDXW = $clog2(HZ_DEPTH);

  typedef struct packed {
    logic [HZ_DEPTH-1:0] alloc;   // claim slot, address unknown
    logic [HZ_DEPTH-1:0] clear;   // release slot
    logic [HZ_DEPTH-1:0] addrWr;  // deliver address to slot
  } slotStrobes_t;
endpackage

// File: rtl/ldHazardCtrl.sv
module ldHazardCtrl
  import ldHazardPkg::*;
#(
  parameter int unsigned DEPTH = HZ_DEPTH,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [IW-1:0] headIdx,
  input  logic          allocValid,
  input  logic [IW-1:0] allocIdx,
  input  logic          addrValid,
  input  logic [IW-1:0] addrIdx,
  input  logic          commitValid,
  input  logic [IW-1:0] commitIdx,
  input  logic          flushValid,
  input  logic [IW-1:0] flushIdx,
  input  logic          flushAll,
  input  logic [IW-1:0] loadIdx,
  output slotStrobes_t  strobes,
  output logic [DEPTH-1:0] olderMask
);

  function automatic logic [IW-1:0] ageOf(input logic [IW-1:0] idx,
                                          input logic [IW-1:0] head);
    return idx - head;  // modulo DEPTH (power of two)
  endfunction

  logic [IW-1:0] loadAge;
  logic [IW-1:0] flushAge;

  assign loadAge  = ageOf(loadIdx, headIdx);
  assign flushAge = ageOf(flushIdx, headIdx);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [IW-1:0] SLOT = IW'(i);
    logic [IW-1:0] slotAge;
    assign slotAge = ageOf(SLOT, headIdx);

    assign olderMask[i]      = slotAge < loadAge;
    assign strobes.alloc[i]  = allocValid && (allocIdx == SLOT) && !flushAll;
    assign strobes.addrWr[i] = addrValid && (addrIdx == SLOT);
    assign strobes.clear[i]  = flushAll
                             || (commitValid && (commitIdx == SLOT))
                             || (flushValid && (slotAge > flushAge));
  end

  // R6: stores leave strictly in order, from the head only
  a_r6_commit_at_head: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> (commitIdx == headIdx));

endmodule

// File: rtl/ldHazardData.sv
module ldHazardData
  import ldHazardPkg::*;
#(
  parameter int unsigned DEPTH = HZ_DEPTH,
  parameter int unsigned ADDRW = HZ_ADDRW
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotStrobes_t     strobes,
  input  logic [ADDRW-1:0] addrValue,
  input  logic [ADDRW-1:0] loadAddr,
  output logic [DEPTH-1:0] hazardMask,
  output logic [DEPTH-1:0] liveMask
);

  logic [DEPTH-1:0] validQ;
  logic [DEPTH-1:0] knownQ;
  logic [ADDRW-1:0] addrQ [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        knownQ[i] <= 1'b0;
        addrQ[i]  <= '0;
      end else if (strobes.alloc[i]) begin
        validQ[i] <= 1'b1;
        knownQ[i] <= 1'b0;
      end else if (strobes.clear[i]) begin
        validQ[i] <= 1'b0;
        knownQ[i] <= 1'b0;
      end else if (strobes.addrWr[i] && validQ[i]) begin
        knownQ[i] <= 1'b1;
        addrQ[i]  <= addrValue;
      end
    end

    // a live slot is a possible writer unless its known address differs
    assign hazardMask[i] = validQ[i] && (!knownQ[i] || (addrQ[i] == loadAddr));

    // R9: allocation starts the slot live with no address
    a_r9_alloc_unknown: assert property (@(posedge clk) disable iff (!rstN)
      strobes.alloc[i] |=> (validQ[i] && !knownQ[i]));

    // R9: address for a dead slot is dropped
    a_r9_dead_addr_ignored: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.addrWr[i] && !validQ[i] && !strobes.alloc[i]) |=> !knownQ[i]);
  end

  assign liveMask = validQ;

endmodule

// File: rtl/ldHazardGate.sv
module ldHazardGate
  import ldHazardPkg::*;
#(
  parameter int unsigned DEPTH = HZ_DEPTH,
  parameter int unsigned ADDRW = HZ_ADDRW,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IW-1:0]    headIdx,
  input  logic             allocValid,
  input  logic [IW-1:0]    allocIdx,
  input  logic             addrValid,
  input  logic [IW-1:0]    addrIdx,
  input  logic [ADDRW-1:0] addrValue,
  input  logic             commitValid,
  input  logic [IW-1:0]    commitIdx,
  input  logic             flushValid,
  input  logic [IW-1:0]    flushIdx,
  input  logic             flushAll,
  input  logic             loadValid,
  input  logic [IW-1:0]    loadIdx,
  input  logic [ADDRW-1:0] loadAddr,
  output logic             loadGrant
);

  slotStrobes_t     strobes;
  logic [DEPTH-1:0] olderMask;
  logic [DEPTH-1:0] hazardMask;
  logic [DEPTH-1:0] liveMask;

  ldHazardCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .headIdx(headIdx),
    .allocValid(allocValid), .allocIdx(allocIdx),
    .addrValid(addrValid), .addrIdx(addrIdx),
    .commitValid(commitValid), .commitIdx(commitIdx),
    .flushValid(flushValid), .flushIdx(flushIdx), .flushAll(flushAll),
    .loadIdx(loadIdx), .strobes(strobes), .olderMask(olderMask)
  );

  ldHazardData #(.DEPTH(DEPTH), .ADDRW(ADDRW)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .addrValue(addrValue), .loadAddr(loadAddr),
    .hazardMask(hazardMask), .liveMask(liveMask)
  );

  assign loadGrant = loadValid && ((olderMask & hazardMask) == '0);

  // R8: no grant without a request
  a_r8_no_idle_grant: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> !loadGrant);

  // R7: full flush leaves nothing live
  a_r7_flushall_empty: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (liveMask == '0));

endmodule

// File: tb/ldHazardGate_tb.sv
module ldHazardGate_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  headIdx = '0;
  logic        allocValid = 1'b0;
  logic [2:0]  allocIdx = '0;
  logic        addrValid = 1'b0;
  logic [2:0]  addrIdx = '0;
  logic [31:0] addrValue = '0;
  logic        commitValid = 1'b0;
  logic [2:0]  commitIdx = '0;
  logic        flushValid = 1'b0;
  logic [2:0]  flushIdx = '0;
  logic        flushAll = 1'b0;
  logic        loadValid = 1'b0;
  logic [2:0]  loadIdx = '0;
  logic [31:0] loadAddr = '0;
  logic        loadGrant;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ldHazardGate u_dut (.*);

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  head;
    logic        aV;  logic [2:0] aI;
    logic        dV;  logic [2:0] dI; logic [31:0] dA;
    logic        cV;  logic [2:0] cI;
    logic        fV;  logic [2:0] fI; logic fAll;
    logic        lV;  logic [2:0] lI; logic [31:0] lA;
    logic        exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // req hd  aV aI  dV dI dA            cV cI  fV fI fAll lV lI lA          exp
    '{8'd1, 3'd0, 1'b0,3'd0, 1'b0,3'd0,32'h0,   1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd3,32'h100, 1'b1}, // R1 empty
    '{8'd2, 3'd0, 1'b1,3'd1, 1'b0,3'd0,32'h0,   1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd3,32'h100, 1'b0}, // R2 unknown older
    '{8'd4, 3'd0, 1'b0,3'd0, 1'b1,3'd1,32'h200, 1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd3,32'h100, 1'b1}, // R4 differs
    '{8'd3, 3'd0, 1'b0,3'd0, 1'b0,3'd0,32'h0,   1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd3,32'h200, 1'b0}, // R3 match
    '{8'd5, 3'd0, 1'b0,3'd0, 1'b0,3'd0,32'h0,   1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd0,32'h200, 1'b1}, // R5 store younger
    '{8'd5, 3'd0, 1'b1,3'd4, 1'b0,3'd0,32'h0,   1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd3,32'h300, 1'b1}, // R5 younger unknown
    '{8'd3, 3'd0, 1'b0,3'd0, 1'b1,3'd4,32'h300, 1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd6,32'h300, 1'b0}, // R3 match slot 4
    '{8'd8, 3'd0, 1'b0,3'd0, 1'b0,3'd0,32'h0,   1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,3'd6,32'h300, 1'b0}, // R8 idle
    '{8'd6, 3'd1, 1'b0,3'd0, 1'b0,3'd0,32'h0,   1'b1,3'd1, 1'b0,3'd0,1'b0, 1'b1,3'd3,32'h200, 1'b1}, // R6 commit frees
    '{8'd7, 3'd1, 1'b0,3'd0, 1'b0,3'd0,32'h0,   1'b0,3'd0, 1'b1,3'd2,1'b0, 1'b1,3'd6,32'h300, 1'b1}, // R7 partial flush
    '{8'd5, 3'd6, 1'b1,3'd7, 1'b0,3'd0,32'h0,   1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd1,32'h500, 1'b0}, // R5 wrap older
    '{8'd4, 3'd6, 1'b0,3'd0, 1'b1,3'd7,32'h500, 1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd0,32'h600, 1'b1}, // R4 wrap differs
    '{8'd3, 3'd6, 1'b1,3'd2, 1'b0,3'd0,32'h0,   1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd1,32'h500, 1'b0}, // R3 wrap match
    '{8'd7, 3'd6, 1'b0,3'd0, 1'b0,3'd0,32'h0,   1'b0,3'd0, 1'b0,3'd0,1'b1, 1'b1,3'd5,32'h500, 1'b1}, // R7 flushAll
    '{8'd9, 3'd0, 1'b1,3'd2, 1'b1,3'd2,32'h700, 1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd5,32'h999, 1'b0}, // R9 addr dropped
    '{8'd3, 3'd0, 1'b0,3'd0, 1'b1,3'd2,32'h700, 1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b1,3'd5,32'h700, 1'b0}, // R3 now known
    '{8'd6, 3'd2, 1'b0,3'd0, 1'b0,3'd0,32'h0,   1'b1,3'd2, 1'b0,3'd0,1'b0, 1'b1,3'd5,32'h700, 1'b1}  // R6 commit frees
  };

  task automatic checkGrant(input string tag, input logic exp);
    checks++;
    if (loadGrant !== exp) begin
      errors++;
      $display("FAIL %s: loadGrant actual=%b expected=%b", tag, loadGrant, exp);
    end
  endtask

  task automatic idleMut();
    allocValid = 1'b0; addrValid = 1'b0; commitValid = 1'b0;
    flushValid = 1'b0; flushAll = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, nothing live
    loadValid = 1'b1; loadIdx = 3'd4; loadAddr = 32'h0; #1;
    checkGrant("R1", 1'b1);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      headIdx = VECS[v].head;
      allocValid = VECS[v].aV; allocIdx = VECS[v].aI;
      addrValid = VECS[v].dV; addrIdx = VECS[v].dI; addrValue = VECS[v].dA;
      commitValid = VECS[v].cV; commitIdx = VECS[v].cI;
      flushValid = VECS[v].fV; flushIdx = VECS[v].fI; flushAll = VECS[v].fAll;
      loadValid = 1'b0;
      @(negedge clk);
      idleMut();
      loadValid = VECS[v].lV; loadIdx = VECS[v].lI; loadAddr = VECS[v].lA;
      #1;
      checkGrant($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].exp);
    end

    // R7: flushAll in the same cycle as an allocation leaves nothing live
    @(negedge clk);
    headIdx = 3'd0; allocValid = 1'b1; allocIdx = 3'd1; flushAll = 1'b1;
    @(negedge clk);
    idleMut();
    loadValid = 1'b1; loadIdx = 3'd3; loadAddr = 32'h42; #1;
    checkGrant("R7 flushAll beats alloc", 1'b1);

    // R2 then R1: a live unknown store blocks, reset clears it
    @(negedge clk);
    allocValid = 1'b1; allocIdx = 3'd2;
    @(negedge clk);
    idleMut(); #1;
    checkGrant("R2 before reset", 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1; #1;
    checkGrant("R1 after reset", 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule